// File: doc/BRIEF.md
# Four-Phase Fetch-Execute Sequencer

This block splits every instruction cycle into four consecutive quarter phases of the input clock. It runs a two-stage pipeline on them. In each instruction cycle, the word at the current program address is fetched. In the same cycle, the word fetched one cycle earlier sits in the instruction register and is executed. The block drives the program-memory address and takes the returned word back. It also provides the per-phase strobes that an execute unit and the data memory use: an operand read strobe in the second phase and a result write strobe in the fourth.

An outside execute unit raises a branch request with a target address. The request is taken only at the last phase of a cycle that is really executing an instruction. The word already prefetched is then thrown away and the instruction register is loaded with the all-zero no-operation word. For the whole next cycle, the flush indicator is high while the target word is fetched. As a result, any instruction that changes the program counter costs two instruction cycles, and all other instructions cost one.

Top module: `qphase_seq`

## Requirements
- R1: `phase` is one-hot with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3, bit 3 = Q4. It advances by one phase on every clock edge in the order Q1, Q2, Q3, Q4, Q1. The first cycle after reset is in Q1.
- R2: `clk_div` is low while `phase` shows Q1 or Q2, and high while it shows Q3 or Q4.
- R3: A clock edge with `rst` high leaves `phase` = Q1, `pc` = 0, `ir` = 0, `flush` = 0, with no data-memory strobe. The first instruction cycle after reset only fetches.
- R4: When no branch is taken, the edge that leaves Q4 increments `pc` by one and loads `ir` with the `pm_rdata` word present in that Q4. `pc` and `ir` hold still at every other edge.
- R5: `dm_rd` is high only in Q2 and `dm_wr` only in Q4, and only in a cycle that executes a fetched word. Neither strobe appears in the fetch-only cycle after reset or in a flush cycle.
- R6: A branch is taken when `br_req` is high at the edge leaving Q4 of an executing cycle. `pc` is then loaded with `br_target` instead of being incremented, `ir` becomes 0, and `flush` is high for all four phases of the next cycle.
- R7: `br_req` has no effect when it is high in Q1, Q2 or Q3, in the fetch-only cycle after reset, or in a flush cycle.
- R8: At the end of a flush cycle, `ir` takes the word read at the branch target, `pc` becomes target + 1, and `flush` falls.
- R9: `pc` is 13 bits wide and wraps from 8191 to 0 on increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four edges per instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| pm_rdata | input | 16 | Word returned by program memory for `pc` |
| br_req | input | 1 | Branch request from the execute unit |
| br_target | input | 13 | Branch destination address |
| pc | output | 13 | Program-memory address being fetched |
| ir | output | 16 | Instruction register (word being executed) |
| phase | output | 4 | One-hot phase strobes Q1..Q4 |
| clk_div | output | 1 | Quarter-rate clock, high in Q3 and Q4 |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory destination write strobe |
| flush | output | 1 | High during the cycle that discards a prefetched word |

## Verification
The assertions check on every cycle that the phase rotates and is one-hot, and that the divided clock follows the phase. They also check that `pc` and `ir` move only when leaving Q4, that the strobes fall in their phases and never during a flush, and how a taken branch and the cycle after it update `pc`, `ir` and `flush`. Some behaviour only the bench scenarios can show. These include the reset state, branch requests that must be ignored (off-phase, in the fetch-only cycle, inside a flush), wrap-around at the top of the address space, and a reset in the middle of a run. The bench compares every output against a behavioural model on every clock.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

    localparam int PC_W_DEF = 13;
    localparam int IW_DEF   = 16;
    localparam int NPH      = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef struct packed {
        logic cyc_end;   // edge leaving Q4
        logic take_br;   // branch accepted at this edge
    } step_t;

    function automatic phase_e ph_next(phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

    function automatic logic [NPH-1:0] ph_onehot(phase_e p);
        return NPH'(1) << p;
    endfunction

endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
    import qseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    output phase_e         ph,
    output logic [NPH-1:0] strobe,
    output logic           clk_div
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_Q1;
            clk_div <= 1'b0;
        end else begin
            ph      <= ph_next(ph);
            // next phase is Q3 or Q4
            clk_div <= (ph == PH_Q2) || (ph == PH_Q3);
        end
    end

    assign strobe = ph_onehot(ph);

endmodule

// File: rtl/qseq_pc_unit.sv
module qseq_pc_unit
    import qseq_pkg::*;
#(
    parameter int PC_W = PC_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  step_t           step,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (step.cyc_end) begin
            pc <= step.take_br ? target : pc + PC_ONE;
        end
    end

endmodule

// File: rtl/qseq_ir_stage.sv
module qseq_ir_stage
    import qseq_pkg::*;
#(
    parameter int IW = IW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  step_t         step,
    input  logic [IW-1:0] fetched,
    output logic [IW-1:0] ir,
    output logic          exec_ok,
    output logic          flush
);

    localparam logic [IW-1:0] NOP_WORD = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir      <= NOP_WORD;
            exec_ok <= 1'b0;
            flush   <= 1'b0;
        end else if (step.cyc_end) begin
            if (step.take_br) begin
                ir      <= NOP_WORD;
                exec_ok <= 1'b0;
                flush   <= 1'b1;
            end else begin
                ir      <= fetched;
                exec_ok <= 1'b1;
                flush   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/qphase_seq.sv
module qphase_seq
    import qseq_pkg::*;
#(
    parameter int PC_W = PC_W_DEF,
    parameter int IW   = IW_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   pm_rdata,
    input  logic            br_req,
    input  logic [PC_W-1:0] br_target,
    output logic [PC_W-1:0] pc,
    output logic [IW-1:0]   ir,
    output logic [NPH-1:0]  phase,
    output logic            clk_div,
    output logic            dm_rd,
    output logic            dm_wr,
    output logic            flush
);

    phase_e ph;
    logic   exec_ok;
    step_t  step;

    qseq_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .ph      (ph),
        .strobe  (phase),
        .clk_div (clk_div)
    );

    always_comb begin
        step.cyc_end = (ph == PH_Q4);
        step.take_br = step.cyc_end && exec_ok && br_req;
    end

    qseq_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .target (br_target),
        .pc     (pc)
    );

    qseq_ir_stage #(.IW(IW)) u_ir (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .fetched (pm_rdata),
        .ir      (ir),
        .exec_ok (exec_ok),
        .flush   (flush)
    );

    assign dm_rd = exec_ok && (ph == PH_Q2);
    assign dm_wr = exec_ok && (ph == PH_Q4);

endmodule

// File: rtl/qphase_seq_chk.sv
module qphase_seq_chk #(
    parameter int PC_W = 13,
    parameter int IW   = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [IW-1:0]   pm_rdata,
    input logic            br_req,
    input logic [PC_W-1:0] br_target,
    input logic [PC_W-1:0] pc,
    input logic [IW-1:0]   ir,
    input logic [3:0]      phase,
    input logic            clk_div,
    input logic            dm_rd,
    input logic            dm_wr,
    input logic            flush
);

    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    assert_rotate_R1: assert property (@(posedge clk) disable iff (rst)
        phase[3] |=> phase[0]);

    assert_divclk_R2: assert property (@(posedge clk) disable iff (rst)
        clk_div == (phase[2] | phase[3]));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !phase[3] |=> $stable(pc) && $stable(ir));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (phase[3] && !br_req) |=>
            (pc == $past(pc) + 1'b1) && (ir == $past(pm_rdata)));

    assert_rd_phase_R5: assert property (@(posedge clk) disable iff (rst)
        dm_rd |-> phase[1] && !flush);

    assert_wr_phase_R5: assert property (@(posedge clk) disable iff (rst)
        dm_wr |-> phase[3] && !flush);

    assert_branch_R6: assert property (@(posedge clk) disable iff (rst)
        (phase[3] && dm_wr && br_req) |=>
            flush && (pc == $past(br_target)) && (ir == '0));

    assert_flush_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (flush && !phase[3]) |=> flush);

    assert_refill_R8: assert property (@(posedge clk) disable iff (rst)
        (flush && phase[3]) |=>
            !flush && (ir == $past(pm_rdata)) && (pc == $past(pc) + 1'b1));

endmodule

bind qphase_seq qphase_seq_chk #(.PC_W(PC_W), .IW(IW)) u_chk (.*);

// File: tb/qphase_seq_tb.sv
module qphase_seq_tb;

    localparam int PC_W = 13;
    localparam int IW   = 16;
    localparam int NCYC = 420;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [IW-1:0]   pm_rdata;
    logic            br_req = 1'b0;
    logic [PC_W-1:0] br_target = '0;
    logic [PC_W-1:0] pc;
    logic [IW-1:0]   ir;
    logic [3:0]      phase;
    logic            clk_div, dm_rd, dm_wr, flush;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    function automatic int mem_word(int a);
        return (a * 2731 + 4951) & 16'hFFFF;
    endfunction

    assign pm_rdata = IW'(mem_word(int'(pc)));

    qphase_seq u_dut (
        .clk(clk), .rst(rst), .pm_rdata(pm_rdata), .br_req(br_req),
        .br_target(br_target), .pc(pc), .ir(ir), .phase(phase),
        .clk_div(clk_div), .dm_rd(dm_rd), .dm_wr(dm_wr), .flush(flush)
    );

    // behavioural reference state
    int  m_ph, m_pc, m_ir, m_icyc;
    bit  m_ev, m_fl;
    string ctx_pc;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_pc = 0; m_ir = 0; m_ev = 0; m_fl = 0; m_icyc = 0;
        ctx_pc = "R3";
    endtask

    initial begin
        model_reset();
        for (int n = 0; n < NCYC; n++) begin
            bit r, b;
            int t;
            @(negedge clk);
            // compare against model
            check("R1 phase", int'(phase), 1 << m_ph);
            check("R2 clk_div", int'(clk_div), (m_ph >= 2) ? 1 : 0);
            check({ctx_pc, " pc"}, int'(pc), m_pc);
            check({ctx_pc, " ir"}, int'(ir), m_ir);
            check({ctx_pc, " flush"}, int'(flush), int'(m_fl));
            check("R5 dm_rd", int'(dm_rd), (m_ev && m_ph == 1) ? 1 : 0);
            check("R5 dm_wr", int'(dm_wr), (m_ev && m_ph == 3) ? 1 : 0);
            // choose inputs for the coming edge
            r = (n < 2) || (n == 300);
            b = 0; t = 55;
            if (m_ph == 3) begin
                case (m_icyc)
                    0:  begin b = 1; t = 100;  end // fetch-only: ignored
                    4:  begin b = 1; t = 200;  end
                    5:  begin b = 1; t = 300;  end // flush cycle: ignored
                    9:  begin b = 1; t = 8191; end
                    14: begin b = 1; t = 8190; end
                    default: ;
                endcase
            end else if (m_ph == 1 && (m_icyc % 3) == 0) begin
                b = 1; t = 77;                    // off-phase: ignored
            end
            rst = r; br_req = b; br_target = PC_W'(t);
            // advance model through the coming edge
            if (r) begin
                model_reset();
            end else begin
                if (m_ph == 3) begin
                    if (m_ev && b) begin
                        m_pc = t; m_ir = 0; m_fl = 1; m_ev = 0;
                        ctx_pc = "R6";
                    end else begin
                        if (m_fl) ctx_pc = "R8";
                        else if (m_pc == 8191) ctx_pc = "R9";
                        else if (b) ctx_pc = "R7";
                        else ctx_pc = "R4";
                        m_ir = mem_word(m_pc);
                        m_pc = (m_pc + 1) % 8192;
                        m_fl = 0; m_ev = 1;
                    end
                    m_icyc++;
                end else begin
                    ctx_pc = b ? "R7" : "R4";
                end
                m_ph = (m_ph + 1) % 4;
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule